// File: doc/BRIEF.md
# SPI Ferroelectric Memory Target

This block is the target side of a byte-addressable nonvolatile RAM on a serial peripheral bus. A host selects it with an active-low chip select and clocks one-byte commands on MOSI in SPI mode 3. The block answers on MISO with status, memory contents or an identification string. All serial inputs pass through synchronizer flops and are sampled by the system clock. The system clock must therefore run at least eight times faster than the serial clock.

The block holds an internal byte array of `MEM_BYTES` locations. Every write completes at once, so the busy flag never reads as set. A write-enable latch gates the memory and status writes. A three-bit protection code fences off a top fraction of the array. The address is sent in `ADDR_BYTES` bytes. The identification bytes are parameters, so one body of RTL can stand in for several capacities.

Top module: `spi_fram_target`

## Requirements
- R1: After reset the status byte reads 0x00 and MISO is low.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. The status byte is {bit7 write-protect flag, 2'b00, bits 4:2 protection code, bit1 latch, bit0 busy}. The busy bit is always 0.
- R3: Opcode 0x03 is followed by ADDR_BYTES address bytes, most significant byte first. The block then returns data from that address, one byte per byte clocked, with the address stepping up by one each time.
- R4: Opcode 0x02 is followed by the address and then data bytes, stored at ascending addresses, but only while the latch is set. Opcode 0x01 with the latch clear changes nothing. The latch clears when chip select rises after either command.
- R5: During reads and writes the address wraps from MEM_BYTES-1 to 0.
- R6: Opcode 0x0B is a read with one dummy byte between the address and the first data byte.
- R7: Opcode 0x01 with the latch set loads status bit 7 and bits 4:2 from the first data byte. Opcode 0x05 returns the status byte, repeated for as long as the host keeps clocking.
- R8: A write to a protected address is dropped. Protection code k = 1..6 protects the top MEM_BYTES/2^(7-k) bytes, code 7 protects every byte, and code 0 protects none.
- R9: Opcode 0x9F returns six bytes of 0x7F, then 0xC2, then ID_CAPACITY, then ID_VARIANT, then 0x00.
- R10: An unknown opcode is ignored until chip select rises. MISO stays 0 while chip select is high and while no data is being returned.
- R11: MOSI is sampled on the rising serial clock edge, and MISO changes only after a falling edge, with the MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The bench goes after the edges of the address space and of protection. A counter that does not wrap would return wrong data at the array top. A protection decoder off by one bit position would either let a write through into the top fraction or block the byte just below it. It also probes the write-enable latch: a latch that never clears would let a second write through without a fresh enable, and a status write accepted without the latch would change the protection code. Finally it checks the identification string length and the unknown-opcode path, where a decoder that leaks state would drive non-zero bits on MISO.

// File: rtl/spi_fram_target.sv
module spi_fram_target #(
  parameter int          MEM_BYTES   = 256,
  parameter int          ADDR_BYTES  = 2,
  parameter logic [7:0]  ID_CAPACITY = 8'h22,
  parameter logic [7:0]  ID_VARIANT  = 8'h00,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int ABITS = 8 * ADDR_BYTES;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FSTRD = 8'h0B;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDID  = 8'h9F;

  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_t;

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic sclk_prev, cs_prev;
  logic sclk_s, cs_s, mosi_s;
  logic sclk_rise, sclk_fall, cs_rise;

  phase_t      phase_q;
  logic [7:0]  op_q;
  logic [6:0]  rx_q;
  logic [2:0]  bit_q;
  logic [1:0]  acnt_q;
  logic [3:0]  id_idx;
  logic [ABITS-1:0] addr_q;
  logic [7:0]  tx_q;
  logic        miso_q;
  logic        wel_q, srwp_q;
  logic [2:0]  bp_q;

  logic [7:0]  mem [MEM_BYTES];

  logic            byte_done, at_opcode, mem_we;
  logic [7:0]      rx_byte, status, rd_byte;
  logic [ABITS-1:0] addr_shift;
  logic [AW-1:0]   addr_idx, idx_inc, new_idx, rd_idx;

  function automatic logic is_prot(input logic [2:0] code, input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = '1;
    m = m << (AW - 7 + int'(code));
    if (code == 3'd0) return 1'b0;
    return (a & m) == m;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    if (k < 4'd6) return 8'h7F;
    case (k)
      4'd6:    return 8'hC2;
      4'd7:    return ID_CAPACITY;
      4'd8:    return ID_VARIANT;
      default: return 8'h00;
    endcase
  endfunction

  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign cs_s   = cs_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];

  assign sclk_rise = !cs_s && sclk_s && !sclk_prev;
  assign sclk_fall = !cs_s && !sclk_s && sclk_prev;
  assign cs_rise   = cs_s && !cs_prev;

  assign byte_done = sclk_rise && (bit_q == 3'd7);
  assign rx_byte   = {rx_q, mosi_s};
  assign at_opcode = (phase_q == PH_OPC);

  assign status     = {srwp_q, 2'b00, bp_q, wel_q, 1'b0};
  assign addr_shift = {addr_q[ABITS-9:0], rx_byte};
  assign addr_idx   = addr_q[AW-1:0];
  assign idx_inc    = addr_idx + 1'b1;
  assign new_idx    = addr_shift[AW-1:0];

  always_comb begin
    case (phase_q)
      PH_ADDR:  rd_idx = new_idx;
      PH_DUMMY: rd_idx = addr_idx;
      default:  rd_idx = idx_inc;
    endcase
  end
  assign rd_byte = mem[rd_idx];

  assign mem_we = byte_done && (phase_q == PH_DATA) && (op_q == OP_WRITE) &&
                  wel_q && !is_prot(bp_q, addr_idx);

  assign spi_miso = miso_q & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '1;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sclk_prev <= 1'b1;
      cs_prev   <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], spi_sclk};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], spi_cs_n};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], spi_mosi};
      sclk_prev <= sclk_s;
      cs_prev   <= cs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr_idx] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;
      op_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      acnt_q  <= '0;
      id_idx  <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
      wel_q   <= 1'b0;
      srwp_q  <= 1'b0;
      bp_q    <= '0;
    end else if (cs_s) begin
      phase_q <= PH_OPC;
      op_q    <= '0;
      bit_q   <= '0;
      acnt_q  <= '0;
      id_idx  <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
      if (cs_rise && (op_q == OP_WRITE || op_q == OP_WRSR)) wel_q <= 1'b0;
    end else begin
      if (sclk_fall) begin
        miso_q <= tx_q[7];
        tx_q   <= {tx_q[6:0], 1'b0};
      end
      if (sclk_rise) begin
        rx_q  <= {rx_q[5:0], mosi_s};
        bit_q <= bit_q + 1'b1;
      end
      if (byte_done) begin
        case (phase_q)
          PH_OPC: begin
            op_q <= rx_byte;
            case (rx_byte)
              OP_WREN: begin wel_q <= 1'b1; phase_q <= PH_SKIP; end
              OP_WRDI: begin wel_q <= 1'b0; phase_q <= PH_SKIP; end
              OP_RDSR: begin tx_q <= status; phase_q <= PH_DATA; end
              OP_WRSR: phase_q <= PH_DATA;
              OP_READ, OP_FSTRD, OP_WRITE: begin
                acnt_q  <= '0;
                phase_q <= PH_ADDR;
              end
              OP_RDID: begin
                tx_q    <= 8'h7F;
                id_idx  <= 4'd1;
                phase_q <= PH_DATA;
              end
              default: phase_q <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            addr_q <= addr_shift;
            acnt_q <= acnt_q + 1'b1;
            if (acnt_q == 2'(ADDR_BYTES - 1)) begin
              if (op_q == OP_FSTRD) phase_q <= PH_DUMMY;
              else begin
                phase_q <= PH_DATA;
                if (op_q == OP_READ) tx_q <= rd_byte;
              end
            end
          end
          PH_DUMMY: begin
            phase_q <= PH_DATA;
            tx_q    <= rd_byte;
          end
          PH_DATA: begin
            case (op_q)
              OP_RDSR: tx_q <= status;
              OP_WRSR: begin
                if (wel_q) begin
                  srwp_q <= rx_byte[7];
                  bp_q   <= rx_byte[4:2];
                end
                phase_q <= PH_SKIP;
              end
              OP_READ, OP_FSTRD: begin
                addr_q <= ABITS'(idx_inc);
                tx_q   <= rd_byte;
              end
              OP_WRITE: addr_q <= ABITS'(idx_inc);
              OP_RDID: begin
                tx_q <= id_byte(id_idx);
                if (id_idx != 4'd9) id_idx <= id_idx + 1'b1;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_fram_target_chk.sv
module spi_fram_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso,
  input logic       cs_s,
  input logic       cs_rise,
  input logic       sclk_fall,
  input logic       byte_done,
  input logic       at_opcode,
  input logic [7:0] rx_byte,
  input logic [7:0] op_q,
  input logic       miso_q,
  input logic       wel_q,
  input logic [2:0] bp_q,
  input logic       mem_we
);
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);

  p_wel_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (op_q == 8'h02 || op_q == 8'h01)) |=> !wel_q);

  p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && at_opcode && rx_byte == 8'h06) |=> wel_q);

  p_wrdi_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && at_opcode && rx_byte == 8'h04) |=> !wel_q);

  p_write_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wel_q && !cs_s));

  p_full_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bp_q != 3'd7));

  p_miso_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !sclk_fall) |=> $stable(miso_q));

  p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(bp_q));
endmodule

bind spi_fram_target spi_fram_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_cs_n  (spi_cs_n),
  .spi_miso  (spi_miso),
  .cs_s      (cs_s),
  .cs_rise   (cs_rise),
  .sclk_fall (sclk_fall),
  .byte_done (byte_done),
  .at_opcode (at_opcode),
  .rx_byte   (rx_byte),
  .op_q      (op_q),
  .miso_q    (miso_q),
  .wel_q     (wel_q),
  .bp_q      (bp_q),
  .mem_we    (mem_we)
);

// File: tb/tb_spi_fram_target.sv
module tb_spi_fram_target;
  localparam int MEM = 256;
  localparam int AB  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b1;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;

  always #2.5 clk = ~clk;

  spi_fram_target #(.MEM_BYTES(MEM), .ADDR_BYTES(AB), .ID_CAPACITY(8'h22),
                    .ID_VARIANT(8'h00), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int hi_cnt = 0;

  logic [7:0] mm [MEM];
  bit         wel_m = 0;
  bit         srwp_m = 0;
  int         bp_m = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit prot_m(input int a);
    if (bp_m == 0) return 0;
    if (bp_m == 7) return 1;
    return a >= MEM - MEM / (2 ** (7 - bp_m));
  endfunction

  function automatic logic [7:0] status_m();
    return {srwp_m, 2'b00, 3'(bp_m), wel_m, 1'b0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_sclk = 1'b0;
      spi_mosi = t[i];
      tick(8);
      r[i] = spi_miso;
      spi_sclk = 1'b1;
      tick(8);
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    tick(8);
  endtask

  task automatic desel();
    tick(8);
    spi_cs_n = 1'b1;
    tick(16);
  endtask

  task automatic send_addr(input int a);
    logic [7:0] r;
    for (int k = AB - 1; k >= 0; k--) xfer(8'((a >> (8 * k)) & 255), r);
  endtask

  task automatic simple(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
    if (op == 8'h06) wel_m = 1;
    if (op == 8'h04) wel_m = 0;
  endtask

  task automatic rdsr_chk(input string req);
    logic [7:0] r;
    sel(); xfer(8'h05, r);
    xfer(8'h00, r); chk(req, r, status_m());
    xfer(8'h00, r); chk({req, " repeat R7"}, r, status_m());
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r); xfer(v, r); desel();
    if (wel_m) begin srwp_m = v[7]; bp_m = int'(v[4:2]); end
    wel_m = 0;
  endtask

  task automatic wr(input int a, input int n, input int base);
    logic [7:0] r, d;
    int ad;
    ad = a;
    sel(); xfer(8'h02, r); send_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'((base + i * 37) & 255);
      xfer(d, r);
      if (wel_m && !prot_m(ad)) mm[ad] = d;
      ad = (ad + 1) % MEM;
    end
    desel();
    wel_m = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] op, input int a, input int n);
    logic [7:0] r;
    int ad;
    ad = a;
    sel(); xfer(op, r); send_addr(a);
    if (op == 8'h0B) xfer(8'hA5, r);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      chk(req, r, mm[ad]);
      ad = (ad + 1) % MEM;
    end
    desel();
  endtask

  always @(negedge clk) begin
    if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
    if (rst_n && hi_cnt >= 4) begin
      checks++;
      if (spi_miso !== 1'b0) begin
        fails++;
        $display("FAIL R10 idle miso actual=%b expected=0", spi_miso);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] idexp;
    for (int i = 0; i < MEM; i++) mm[i] = 8'h00;
    tick(10);
    rst_n = 1'b1;
    tick(10);

    chk("R1 miso after reset", {7'd0, spi_miso}, 8'h00);
    rdsr_chk("R1 reset status");

    simple(8'h06);
    rdsr_chk("R2 latch set");
    simple(8'h04);
    rdsr_chk("R2 latch clear");

    simple(8'h06);
    wr(0, MEM, 11);
    rdsr_chk("R4 latch cleared after write");
    rd("R3 R11 read fill", 8'h03, 0, 8);
    rd("R3 read mid", 8'h03, 100, 6);

    wr(10, 3, 200);
    rd("R4 write without latch ignored", 8'h03, 10, 3);

    simple(8'h06);
    wr(MEM - 2, 3, 77);
    rd("R5 wrap", 8'h03, MEM - 2, 3);

    rd("R6 fast read", 8'h0B, 20, 4);

    wrsr(8'h9C);
    rdsr_chk("R4 status write without latch");
    simple(8'h06);
    wrsr(8'h84);
    rdsr_chk("R7 status written");

    simple(8'h06);
    wr(MEM - 6, 4, 5);
    rd("R8 top 1/64 protected", 8'h03, MEM - 6, 4);

    simple(8'h06);
    wrsr(8'h18);
    simple(8'h06);
    wr(MEM / 2 - 2, 4, 9);
    rd("R8 upper half protected", 8'h03, MEM / 2 - 2, 4);

    simple(8'h06);
    wrsr(8'h1C);
    simple(8'h06);
    wr(0, 2, 3);
    rd("R8 all protected", 8'h03, 0, 2);

    simple(8'h06);
    wrsr(8'h00);
    simple(8'h06);
    wr(0, 2, 3);
    rd("R8 unprotected again", 8'h03, 0, 2);

    sel(); xfer(8'h9F, r);
    for (int i = 0; i < 10; i++) begin
      xfer(8'h00, r);
      idexp = (i < 6) ? 8'h7F : (i == 6) ? 8'hC2 : (i == 7) ? 8'h22 : 8'h00;
      chk("R9 id byte", r, idexp);
    end
    desel();

    simple(8'h06);
    sel(); xfer(8'hAB, r);
    for (int i = 0; i < 3; i++) begin
      xfer(8'hFF, r);
      chk("R10 unknown opcode miso", r, 8'h00);
    end
    desel();
    rdsr_chk("R10 unknown opcode leaves status");

    finished = 1;
    summary();
    $finish;
  end
endmodule